// File: doc/BRIEF.md
# Register File with Dual-Source Write

This block is a small clocked register file with one write port and one read port. The write port and the read port have their own addresses. The word to be written is taken from one of two input buses, and a select line picks which one. It is meant to sit inside a datapath where two producers, such as an ALU result and a load result, share a single write port. In that setting the select line replaces an external multiplexer.

Reads are combinational while the read enable is high. While the read enable is low, the read bus holds the last word that was captured at a clock edge with the read enable high. A build-time option turns entry zero into a constant zero. Every write to that entry is then ignored, and every read of it returns zero. The storage words have no reset. Only the read-hold register is cleared by the synchronous active-low reset.

Top module: `dual_src_regfile`

## Requirements
- R1: With `wr_en` = 1 and `wr_src_sel` = 0, the rising edge of `clk` stores `wr_data_a` into the entry at `wr_addr`.
- R2: With `wr_en` = 1 and `wr_src_sel` = 1, the rising edge stores `wr_data_b` into the entry at `wr_addr`.
- R3: With `wr_en` = 0, no entry changes at the edge, whatever the values of the address, data and select inputs.
- R4: With `rd_en` = 1, `rd_data` shows the entry at `rd_addr` in the same cycle, without waiting for a clock edge.
- R5: With `rd_en` = 0, `rd_data` keeps the word captured at the last rising edge that had `rd_en` = 1. Writes to any entry and changes of `rd_addr` do not alter it.
- R6: When a read and a write target the same address in one cycle, the read returns the old word before the edge and the new word after the edge.
- R7: With `ZERO_ENTRY` = 1, a read of address 0 returns all zeros, including after writes to address 0. A held read of address 0 also gives zero.
- R8: With `ZERO_ENTRY` = 0, entry 0 stores and returns data like any other entry.
- R9: A write changes only the entry at `wr_addr`. `rd_addr` and `wr_addr` are fully independent.
- R10: A rising edge with `rst_n` = 0 clears the read-hold register, so `rd_data` reads zero while `rd_en` = 0 after reset.
- R11: `DEPTH` must be a power of two of at least 2. Any other value stops elaboration. Address width is log2(`DEPTH`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and hold capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read-hold register |
| wr_src_sel | input | 1 | Write source select: 0 picks `wr_data_a`, 1 picks `wr_data_b` |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable: 1 reads through, 0 holds |
| rd_addr | input | log2(DEPTH) | Read address |
| wr_addr | input | log2(DEPTH) | Write address |
| wr_data_a | input | WIDTH | First write source |
| wr_data_b | input | WIDTH | Second write source |
| rd_data | output | WIDTH | Read data |

## Verification
A wrong write decode or a wrong source choice leaves a bad word in one entry. That fault stays hidden until the entry is read. For this reason the bench reads every entry after each sweep of writes, and each entry holds a distinct value. A faulty hold register shows up in the first cycle after `rd_en` falls, once the read address or the targeted word changes. A zero entry that leaks shows up on the first read of address 0 after a write to it.

// File: rtl/rf_pkg.sv
// Package: shared helpers for the dual-source register file.
// Assumes: parameters are elaboration-time integers.
package rf_pkg;

    // Returns 1 when v is a power of two no smaller than 2.
    function automatic bit depth_ok(input int v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rf_wr_front.sv
// Module: write front end. Chooses the write word from two sources and
// decodes the write address into a one-hot enable per entry.
// Assumes: DEPTH is a power of two (checked at the top).
module rf_wr_front #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             src_sel,
    input  logic             wen,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] wword,
    output logic [DEPTH-1:0] went
);

    // Pick the write word from the selected source bus.
    always_comb begin
        wword = src_sel ? src_b : src_a;
    end

    // One enable line per entry, high only for the addressed entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign went[i] = wen && (waddr == AW'(i));
    end

endmodule

// File: rtl/rf_store.sv
// Module: storage array. Each entry is a plain register loaded when its
// decoded enable is high. With ZERO_ENTRY set, entry 0 is constant zero.
// Assumes: went is one-hot or zero; storage carries no reset.
module rf_store #(
    parameter int WIDTH      = 32,
    parameter int DEPTH      = 8,
    parameter bit ZERO_ENTRY = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             went,
    input  logic [WIDTH-1:0]             wword,
    output logic [DEPTH-1:0][WIDTH-1:0]  q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (ZERO_ENTRY && (i == 0)) begin : g_zero
            logic unused_went0;
            assign unused_went0 = went[i];
            // Entry zero is tied off; its write enable is ignored.
            assign q[i] = '0;
        end else begin : g_reg
            logic [WIDTH-1:0] word_q;

            // Load the entry on its decoded write enable.
            always_ff @(posedge clk) begin
                if (went[i]) word_q <= wword;
            end

            assign q[i] = word_q;

            // R1/R2: an enabled entry holds the chosen write word after the edge.
            p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
                went[i] |=> (q[i] == $past(wword)));

            // R3: an entry with no enable keeps its word.
            p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!went[i] && rst_n) |=> $stable(q[i]));
        end
    end

endmodule

// File: rtl/rf_rd_back.sv
// Module: read back end. Selects the addressed entry and holds the last
// word captured at an edge while the read enable is low.
// Assumes: synchronous active-low reset clears only the hold register.
module rf_rd_back #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ren,
    input  logic [AW-1:0]                raddr,
    input  logic [DEPTH-1:0][WIDTH-1:0]  q,
    output logic [WIDTH-1:0]             rdata
);

    logic [WIDTH-1:0] sel_word;
    logic [WIDTH-1:0] hold_q;

    // Index the array with the read address.
    always_comb begin
        sel_word = q[raddr];
    end

    // Capture the read word on edges with the read enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)   hold_q <= '0;
        else if (ren) hold_q <= sel_word;
    end

    // Read through when enabled, otherwise show the held word.
    always_comb begin
        rdata = ren ? sel_word : hold_q;
    end

    // R10: reset leaves the hold register at zero.
    p_hold_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (hold_q == '0));

endmodule

// File: rtl/dual_src_regfile.sv
// Module: top of the dual-source register file. One write port fed from
// two buses through a select, one read port with read-through or hold.
// Assumes: DEPTH is a power of two >= 2; no write-to-read bypass.
module dual_src_regfile #(
    parameter int WIDTH      = 32,
    parameter int DEPTH      = 8,
    parameter bit ZERO_ENTRY = 1'b1,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_src_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data_a,
    input  logic [WIDTH-1:0] wr_data_b,
    output logic [WIDTH-1:0] rd_data
);

    // R11: reject depths that are not a power of two of at least 2.
    if (!rf_pkg::depth_ok(DEPTH)) begin : g_bad_depth
        $error("dual_src_regfile: DEPTH must be a power of two >= 2");
    end

    logic [WIDTH-1:0]             wword;
    logic [DEPTH-1:0]             went;
    logic [DEPTH-1:0][WIDTH-1:0]  q;

    rf_wr_front #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_front (
        .src_sel (wr_src_sel),
        .wen     (wr_en),
        .waddr   (wr_addr),
        .src_a   (wr_data_a),
        .src_b   (wr_data_b),
        .wword   (wword),
        .went    (went)
    );

    rf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ZERO_ENTRY(ZERO_ENTRY)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .went  (went),
        .wword (wword),
        .q     (q)
    );

    rf_rd_back #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_back (
        .clk   (clk),
        .rst_n (rst_n),
        .ren   (rd_en),
        .raddr (rd_addr),
        .q     (q),
        .rdata (rd_data)
    );

    // R9: at most one entry is enabled for a write.
    p_one_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(went));

    // R5: two edges in a row with reads disabled leave the output unchanged.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(!rd_en) && $past(rst_n)) |-> $stable(rd_data));

    // R7: with the zero option, reading address 0 yields zero.
    p_zero_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_ENTRY && rd_en && (rd_addr == '0)) |-> (rd_data == '0));

endmodule

// File: tb/dual_src_regfile_tb.sv
module dual_src_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int D  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [AW-1:0] radr = '0, wadr = '0;
    logic [W-1:0]  da = '0, db = '0;
    logic [W-1:0]  dout_z, dout_p;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] mz [D];
    logic [W-1:0] mp [D];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_src_regfile #(.WIDTH(W), .DEPTH(D), .ZERO_ENTRY(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_src_sel(sel), .wr_en(wen), .rd_en(ren),
        .rd_addr(radr), .wr_addr(wadr), .wr_data_a(da), .wr_data_b(db),
        .rd_data(dout_z));

    dual_src_regfile #(.WIDTH(W), .DEPTH(D), .ZERO_ENTRY(1'b0)) u_dut_plain (
        .clk(clk), .rst_n(rst_n), .wr_src_sel(sel), .wr_en(wen), .rd_en(ren),
        .rd_addr(radr), .wr_addr(wadr), .wr_data_a(da), .wr_data_b(db),
        .rd_data(dout_p));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write cycle; inputs driven at the falling edge.
    task automatic do_write(input logic [AW-1:0] a, input logic s,
                            input logic [W-1:0] va, input logic [W-1:0] vb);
        @(negedge clk);
        wen = 1'b1; wadr = a; sel = s; da = va; db = vb;
        @(posedge clk);
        if (a != 0) mz[a] = s ? vb : va;
        mp[a] = s ? vb : va;
        @(negedge clk);
        wen = 1'b0;
    endtask

    // Read-through check of both instances.
    task automatic rd_check(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        ren = 1'b1; radr = a;
        #2;
        chk(req, dout_z, (a == 0) ? '0 : mz[a]);
        chk(req, dout_p, mp[a]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset clears the hold register.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R10", dout_z, '0);
        chk("R10", dout_p, '0);

        // R1/R2/R8/R9: fill every entry, source chosen by address bit 0.
        for (int a = 0; a < D; a++)
            do_write(AW'(a), a[0], W'(a * 17 + 3), W'(a * 29 + 100));
        for (int a = 0; a < D; a++) rd_check(a[0] ? "R2" : "R1", AW'(a));

        // R1/R2 again with sources swapped; R8 covers entry 0 of the plain copy.
        for (int a = 0; a < D; a++)
            do_write(AW'(a), ~a[0], W'(a * 13 + 7), W'(255 - a * 11));
        for (int a = 0; a < D; a++) rd_check("R9", AW'(a));
        rd_check("R8", '0);

        // R3: disabled writes leave everything unchanged.
        for (int a = 0; a < D; a++) begin
            @(negedge clk);
            wen = 1'b0; wadr = AW'(a); sel = a[0]; da = 8'hEE; db = 8'hDD;
            @(posedge clk);
        end
        for (int a = 0; a < D; a++) rd_check("R3", AW'(a));

        // R7: writes to entry 0 ignored with the zero option.
        do_write('0, 1'b0, 8'h5A, 8'hA5);
        do_write('0, 1'b1, 8'h5A, 8'hA5);
        rd_check("R7", '0);

        // R4: read address sweep while a write to another entry is pending.
        for (int a = 0; a < D; a++) begin
            @(negedge clk);
            ren = 1'b1; radr = AW'(a); wadr = AW'(D - 1 - a); wen = 1'b0;
            #1;
            chk("R4", dout_p, mp[a]);
        end

        // R6: same-address read and write in one cycle.
        @(negedge clk);
        ren = 1'b1; radr = 3'd3; wen = 1'b1; wadr = 3'd3; sel = 1'b1; db = 8'h77; da = 8'h11;
        #2;
        chk("R6", dout_z, mz[3]);
        chk("R6", dout_p, mp[3]);
        @(posedge clk);
        mz[3] = 8'h77; mp[3] = 8'h77;
        #2;
        chk("R6", dout_z, 8'h77);
        chk("R6", dout_p, 8'h77);
        @(negedge clk);
        wen = 1'b0;

        // R5: capture entry 5, then hold through address changes and a write.
        rd_check("R5", 3'd5);
        @(posedge clk);
        @(negedge clk);
        ren = 1'b0; radr = 3'd2;
        #2;
        chk("R5", dout_z, mz[5]);
        chk("R5", dout_p, mp[5]);
        begin
            logic [W-1:0] hz, hp;
            hz = mz[5]; hp = mp[5];
            do_write(3'd5, 1'b0, 8'hC3, 8'h3C);
            #2;
            chk("R5", dout_z, hz);
            chk("R5", dout_p, hp);
        end

        // R7: held read of address 0 is zero with the zero option.
        rd_check("R7", '0);
        @(posedge clk);
        @(negedge clk);
        ren = 1'b0; radr = 3'd6;
        #2;
        chk("R7", dout_z, '0);
        chk("R8", dout_p, mp[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule